// File: doc/BRIEF.md
# Interrupt Gate Descriptor Checker

This block checks an interrupt descriptor table entry before an interrupt or exception is delivered through it. The caller presents a vector number, a flag that says whether a software interrupt instruction raised it, the current privilege level, the table limit, a mode select (32-bit protected or 64-bit) and the raw descriptor: one low quadword in protected mode, a low and a high quadword in 64-bit mode. One clock later the block reports one of two results. The entry either passes, or it fails with a fault vector and an error code.

The rules are applied in a fixed priority order, and only the first rule that fails is reported. Faults that concern the table entry itself carry an error code of the vector times the entry size plus 2. A passing entry yields the decoded target selector, the target offset, the stack-table index, a flag for interrupt versus trap gate, and a flag for a task gate. Fetching the code segment descriptor and building the stack frame happen downstream.

Top module: `int_gate_checker`

## Requirements
- R1: A request sampled with `req_valid` high at a rising edge produces its result on the outputs after that edge, with `rsp_valid` high for exactly that one cycle. With no request, `rsp_valid`, `pass` and `fault` are low.
- R2: Limit check. In protected mode (`long_mode`=0) the entry fails when vector*8+7 exceeds `tbl_limit`. In 64-bit mode the test is vector*16+15. Both give fault vector 13 with error code vector*8+2 or vector*16+2 respectively. An entry whose last byte equals the limit passes this check.
- R3: In 64-bit mode, any nonzero bit among `desc_hi[44:40]` gives fault 13 with error code vector*16+2. In protected mode these bits are ignored.
- R4: The gate type is `desc_lo[43:40]` and the segment flag is `desc_lo[44]`. Protected mode accepts types 5, 6, 7, 14 and 15. 64-bit mode accepts only 14 and 15. Any other type, or a segment flag of 1, gives fault 13 with the entry error code.
- R5: When `sw_int`=1 and the gate privilege `desc_lo[46:45]` is numerically below `cpl`, the result is fault 13 with the entry error code. When `sw_int`=0 this rule has no effect.
- R6: A clear present bit `desc_lo[47]` gives fault 11 with the entry error code.
- R7: For interrupt and trap gates (any accepted type except 5), a target selector `desc_lo[31:16]` whose bits 15:2 are all zero gives fault 13 with error code 0. Task gates skip this rule.
- R8: The rules are ordered limit, reserved bits, type, privilege, present, selector. Only the first failing rule is reported.
- R9: On pass, the outputs are set as follows:
  - `tgt_sel` = `desc_lo[31:16]`.
  - `int_gate` is 1 for an even type and 0 for an odd type.
  - `task_gate` is 1 for type 5.
  - `tgt_off` = {`desc_lo[63:48]`,`desc_lo[15:0]`}, zero-extended, in protected mode, and {`desc_hi[31:0]`,`desc_lo[63:48]`,`desc_lo[15:0]`} in 64-bit mode. For a task gate it is 0.
  - `stack_idx` = `desc_lo[34:32]` in 64-bit mode and 0 in protected mode.
  - `fault_vec` and `err_code` are 0.
- R10: A response has exactly one of `pass` and `fault` high. On fault, `tgt_sel`, `tgt_off`, `stack_idx`, `int_gate` and `task_gate` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| vector | input | 8 | Interrupt vector number |
| sw_int | input | 1 | Raised by a software interrupt instruction |
| cpl | input | 2 | Current privilege level |
| tbl_limit | input | 16 | Descriptor table limit in bytes |
| long_mode | input | 1 | 1 = 64-bit mode, 0 = protected mode |
| desc_lo | input | 64 | Low quadword of the gate descriptor |
| desc_hi | input | 64 | High quadword of the gate descriptor (64-bit mode) |
| rsp_valid | output | 1 | Result strobe |
| pass | output | 1 | Entry accepted |
| fault | output | 1 | Entry rejected |
| fault_vec | output | 8 | Fault vector (13 or 11) |
| err_code | output | 16 | Fault error code |
| tgt_sel | output | 16 | Target selector |
| tgt_off | output | 64 | Target offset |
| stack_idx | output | 3 | Stack-table index |
| int_gate | output | 1 | Interrupt gate, so the interrupt-enable flag must be cleared |
| task_gate | output | 1 | Task gate |

## Verification
All state lives in one rank of response registers, so a wrong rule decision shows on the response strobe after a single edge. It appears as the wrong fault vector, an error code off by the entry scaling, or a pass where a fault was due. Priority faults show when two rules fail together and the reported fault is the later rule's. Field-slicing faults show as a target offset or stack index that differs from the offset or index placed in the descriptor.

// File: rtl/igc_pkg.sv
package igc_pkg;
    localparam int VEC_W = 8;
    localparam int LIM_W = 16;
    localparam int ERR_W = 16;
    localparam int SEL_W = 16;
    localparam int OFF_W = 64;
    localparam int IST_W = 3;
    localparam int SUM_W = ERR_W + 1;

    localparam logic [VEC_W-1:0] VEC_GP = VEC_W'(13);
    localparam logic [VEC_W-1:0] VEC_NP = VEC_W'(11);

    typedef enum logic [2:0] {
        RULE_OK, RULE_LIMIT, RULE_RSVD, RULE_TYPE, RULE_PRIV, RULE_PRESENT, RULE_SEL
    } rule_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [OFF_W-1:0] off;
        logic [3:0]       gtype;
        logic             seg;
        logic [1:0]       dpl;
        logic             present;
        logic [IST_W-1:0] ist;
        logic [4:0]       rsvd;
    } gate_t;

    function automatic logic type_ok(input logic [3:0] t, input logic lm);
        if (lm) return (t == 4'd14) || (t == 4'd15);
        return (t == 4'd5) || (t == 4'd6) || (t == 4'd7) || (t == 4'd14) || (t == 4'd15);
    endfunction

    function automatic logic [SUM_W-1:0] entry_base(input logic [VEC_W-1:0] v, input logic lm);
        return lm ? (SUM_W'(v) << 4) : (SUM_W'(v) << 3);
    endfunction
endpackage

// File: rtl/gate_field_decode.sv
module gate_field_decode
    import igc_pkg::*;
(
    input  logic [63:0] desc_lo,
    input  logic [63:0] desc_hi,
    input  logic        long_mode,
    output gate_t       gate
);
    logic [31:0] off_lo;
    assign off_lo = {desc_lo[63:48], desc_lo[15:0]};

    always_comb begin
        gate.sel     = desc_lo[31:16];
        gate.gtype   = desc_lo[43:40];
        gate.seg     = desc_lo[44];
        gate.dpl     = desc_lo[46:45];
        gate.present = desc_lo[47];
        gate.ist     = long_mode ? desc_lo[34:32] : '0;
        gate.rsvd    = long_mode ? desc_hi[44:40] : '0;
        gate.off     = long_mode ? {desc_hi[31:0], off_lo} : {32'd0, off_lo};
    end
endmodule

// File: rtl/gate_rule_chain.sv
module gate_rule_chain
    import igc_pkg::*;
(
    input  gate_t            gate,
    input  logic [VEC_W-1:0] vector,
    input  logic             sw_int,
    input  logic [1:0]       cpl,
    input  logic [LIM_W-1:0] tbl_limit,
    input  logic             long_mode,
    output rule_e            verdict,
    output logic [VEC_W-1:0] flt_vec,
    output logic [ERR_W-1:0] flt_err
);
    logic [SUM_W-1:0] base;
    logic [SUM_W-1:0] last_byte;
    logic [ERR_W-1:0] entry_err;
    logic             is_task;

    assign base      = entry_base(vector, long_mode);
    assign last_byte = base + (long_mode ? SUM_W'(15) : SUM_W'(7));
    assign entry_err = ERR_W'(base + SUM_W'(2));
    assign is_task   = (gate.gtype == 4'd5);

    always_comb begin
        if (last_byte > SUM_W'(tbl_limit))                 verdict = RULE_LIMIT;
        else if (gate.rsvd != '0)                          verdict = RULE_RSVD;
        else if (gate.seg || !type_ok(gate.gtype, long_mode)) verdict = RULE_TYPE;
        else if (sw_int && (gate.dpl < cpl))               verdict = RULE_PRIV;
        else if (!gate.present)                            verdict = RULE_PRESENT;
        else if (!is_task && (gate.sel[SEL_W-1:2] == '0))  verdict = RULE_SEL;
        else                                               verdict = RULE_OK;
    end

    always_comb begin
        unique case (verdict)
            RULE_OK:      begin flt_vec = '0;     flt_err = '0;        end
            RULE_PRESENT: begin flt_vec = VEC_NP; flt_err = entry_err; end
            RULE_SEL:     begin flt_vec = VEC_GP; flt_err = '0;        end
            default:      begin flt_vec = VEC_GP; flt_err = entry_err; end
        endcase
    end
endmodule

// File: rtl/int_gate_checker.sv
module int_gate_checker
    import igc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [VEC_W-1:0] vector,
    input  logic             sw_int,
    input  logic [1:0]       cpl,
    input  logic [LIM_W-1:0] tbl_limit,
    input  logic             long_mode,
    input  logic [63:0]      desc_lo,
    input  logic [63:0]      desc_hi,
    output logic             rsp_valid,
    output logic             pass,
    output logic             fault,
    output logic [VEC_W-1:0] fault_vec,
    output logic [ERR_W-1:0] err_code,
    output logic [SEL_W-1:0] tgt_sel,
    output logic [OFF_W-1:0] tgt_off,
    output logic [IST_W-1:0] stack_idx,
    output logic             int_gate,
    output logic             task_gate
);
    gate_t            gate;
    rule_e            verdict;
    logic [VEC_W-1:0] flt_vec;
    logic [ERR_W-1:0] flt_err;
    logic             ok;
    logic             is_task;

    gate_field_decode u_decode (
        .desc_lo(desc_lo), .desc_hi(desc_hi), .long_mode(long_mode), .gate(gate)
    );

    gate_rule_chain u_rules (
        .gate(gate), .vector(vector), .sw_int(sw_int), .cpl(cpl),
        .tbl_limit(tbl_limit), .long_mode(long_mode),
        .verdict(verdict), .flt_vec(flt_vec), .flt_err(flt_err)
    );

    assign ok      = (verdict == RULE_OK);
    assign is_task = (gate.gtype == 4'd5);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            pass      <= 1'b0;
            fault     <= 1'b0;
            fault_vec <= '0;
            err_code  <= '0;
            tgt_sel   <= '0;
            tgt_off   <= '0;
            stack_idx <= '0;
            int_gate  <= 1'b0;
            task_gate <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            pass      <= req_valid && ok;
            fault     <= req_valid && !ok;
            if (req_valid) begin
                fault_vec <= flt_vec;
                err_code  <= flt_err;
                tgt_sel   <= ok ? gate.sel : '0;
                tgt_off   <= (ok && !is_task) ? gate.off : '0;
                stack_idx <= ok ? gate.ist : '0;
                int_gate  <= ok && !is_task && !gate.gtype[0];
                task_gate <= ok && is_task;
            end
        end
    end

    p_one_cycle_r1: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_no_spurious_r1: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid));
    p_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (pass ^ fault));
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!pass && !fault));
    p_fault_kind_r6: assert property (@(posedge clk) disable iff (rst)
        fault |-> (fault_vec == VEC_GP || fault_vec == VEC_NP));
    p_np_code_r6: assert property (@(posedge clk) disable iff (rst)
        (fault && fault_vec == VEC_NP) |-> (err_code[1:0] == 2'b10));
    p_fault_clear_r10: assert property (@(posedge clk) disable iff (rst)
        fault |-> (tgt_sel == '0 && tgt_off == '0 && !int_gate && !task_gate));
    p_prot_ist_r9: assert property (@(posedge clk) disable iff (rst)
        (pass && !$past(long_mode)) |-> (stack_idx == '0));
    p_gate_flags_r9: assert property (@(posedge clk) disable iff (rst)
        !(int_gate && task_gate));
endmodule

// File: tb/test_int_gate_checker.sv
module test_int_gate_checker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [7:0]  vector = '0;
    logic        sw_int = 1'b0;
    logic [1:0]  cpl = '0;
    logic [15:0] tbl_limit = '0;
    logic        long_mode = 1'b0;
    logic [63:0] desc_lo = '0;
    logic [63:0] desc_hi = '0;
    logic        rsp_valid, pass, fault, int_gate, task_gate;
    logic [7:0]  fault_vec;
    logic [15:0] err_code, tgt_sel;
    logic [63:0] tgt_off;
    logic [2:0]  stack_idx;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    int_gate_checker i_int_gate_checker (
        .clk(clk), .rst(rst), .req_valid(req_valid), .vector(vector), .sw_int(sw_int),
        .cpl(cpl), .tbl_limit(tbl_limit), .long_mode(long_mode), .desc_lo(desc_lo),
        .desc_hi(desc_hi), .rsp_valid(rsp_valid), .pass(pass), .fault(fault),
        .fault_vec(fault_vec), .err_code(err_code), .tgt_sel(tgt_sel), .tgt_off(tgt_off),
        .stack_idx(stack_idx), .int_gate(int_gate), .task_gate(task_gate)
    );

    function automatic logic [63:0] mk(input logic [15:0] sel, input logic [31:0] off,
                                       input logic [3:0] t, input logic s, input logic [1:0] dpl,
                                       input logic p, input logic [2:0] ist);
        return {off[31:16], p, dpl, s, t, 5'b0, ist, sel, off[15:0]};
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic issue(input logic [7:0] v, input logic sw, input logic [1:0] pl,
                         input logic [15:0] lim, input logic lm,
                         input logic [63:0] lo, input logic [63:0] hi);
        @(negedge clk);
        vector = v; sw_int = sw; cpl = pl; tbl_limit = lim; long_mode = lm;
        desc_lo = lo; desc_hi = hi; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_fault(input string tag, input logic [7:0] fv, input logic [15:0] ec);
        chk({tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
        chk({tag, " fault"}, 64'(fault), 64'd1);
        chk({tag, " pass"}, 64'(pass), 64'd0);
        chk({tag, " vec"}, 64'(fault_vec), 64'(fv));
        chk({tag, " err"}, 64'(err_code), 64'(ec));
        chk({tag, " R10 sel cleared"}, 64'(tgt_sel), 64'd0);
    endtask

    task automatic expect_pass(input string tag, input logic [15:0] sel, input logic [63:0] off,
                               input logic [2:0] ist, input logic ig, input logic tg);
        chk({tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
        chk({tag, " pass"}, 64'(pass), 64'd1);
        chk({tag, " fault"}, 64'(fault), 64'd0);
        chk({tag, " sel"}, 64'(tgt_sel), 64'(sel));
        chk({tag, " off"}, tgt_off, off);
        chk({tag, " ist"}, 64'(stack_idx), 64'(ist));
        chk({tag, " int_gate"}, 64'(int_gate), 64'(ig));
        chk({tag, " task_gate"}, 64'(task_gate), 64'(tg));
        chk({tag, " err"}, 64'(err_code), 64'd0);
    endtask

    task automatic t_reset;
        chk("R1 reset rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R1 reset pass", 64'(pass), 64'd0);
        chk("R1 reset fault", 64'(fault), 64'd0);
    endtask

    task automatic t_pass_prot;
        issue(8'd3, 1'b0, 2'd0, 16'h00FF, 1'b0, mk(16'h0008, 32'h1234_5678, 4'd14, 0, 0, 1, 3'd5), 64'h0);
        expect_pass("R9 prot int", 16'h0008, 64'h1234_5678, 3'd0, 1'b1, 1'b0);
        issue(8'd4, 1'b0, 2'd0, 16'h00FF, 1'b0, mk(16'h0010, 32'hCAFE_0001, 4'd15, 0, 0, 1, 3'd0), 64'h0);
        expect_pass("R9 prot trap", 16'h0010, 64'hCAFE_0001, 3'd0, 1'b0, 1'b0);
        issue(8'd5, 1'b0, 2'd0, 16'h00FF, 1'b0, mk(16'h0000, 32'h0, 4'd5, 0, 0, 1, 3'd0), 64'h0);
        expect_pass("R7 task gate skips selector", 16'h0000, 64'h0, 3'd0, 1'b0, 1'b1);
    endtask

    task automatic t_pass_long;
        issue(8'd2, 1'b0, 2'd0, 16'h0FFF, 1'b1, mk(16'h0018, 32'hAABB_CCDD, 4'd14, 0, 0, 1, 3'd5),
              64'h0000_0000_8765_4321);
        expect_pass("R9 long int", 16'h0018, 64'h8765_4321_AABB_CCDD, 3'd5, 1'b1, 1'b0);
    endtask

    task automatic t_limit;
        issue(8'd32, 1'b0, 2'd0, 16'h00FF, 1'b0, mk(16'h0008, 32'h10, 4'd14, 0, 0, 1, 0), 64'h0);
        expect_fault("R2 prot over", 8'd13, 16'd258);
        issue(8'd31, 1'b0, 2'd0, 16'h00FF, 1'b0, mk(16'h0008, 32'h10, 4'd14, 0, 0, 1, 0), 64'h0);
        expect_pass("R2 prot at limit", 16'h0008, 64'h10, 3'd0, 1'b1, 1'b0);
        issue(8'd16, 1'b0, 2'd0, 16'h00FF, 1'b1, mk(16'h0008, 32'h10, 4'd14, 0, 0, 1, 0), 64'h0);
        expect_fault("R2 long over", 8'd13, 16'd258);
        issue(8'd15, 1'b0, 2'd0, 16'h00FF, 1'b1, mk(16'h0008, 32'h10, 4'd14, 0, 0, 1, 0), 64'h0);
        expect_pass("R2 long at limit", 16'h0008, 64'h10, 3'd0, 1'b1, 1'b0);
    endtask

    task automatic t_rsvd;
        issue(8'd6, 1'b0, 2'd0, 16'h0FFF, 1'b1, mk(16'h0008, 32'h20, 4'd14, 0, 0, 1, 0), 64'h0000_0400_0000_0000);
        expect_fault("R3 long rsvd", 8'd13, 16'd98);
        issue(8'd6, 1'b0, 2'd0, 16'h0FFF, 1'b0, mk(16'h0008, 32'h20, 4'd14, 0, 0, 1, 0), 64'h0000_1F00_0000_0000);
        expect_pass("R3 prot ignores rsvd", 16'h0008, 64'h20, 3'd0, 1'b1, 1'b0);
    endtask

    task automatic t_type;
        issue(8'd7, 1'b0, 2'd0, 16'h0FFF, 1'b0, mk(16'h0008, 32'h0, 4'd12, 0, 0, 1, 0), 64'h0);
        expect_fault("R4 prot bad type", 8'd13, 16'd58);
        issue(8'd7, 1'b0, 2'd0, 16'h0FFF, 1'b1, mk(16'h0008, 32'h0, 4'd6, 0, 0, 1, 0), 64'h0);
        expect_fault("R4 long rejects 6", 8'd13, 16'd114);
        issue(8'd7, 1'b0, 2'd0, 16'h0FFF, 1'b0, mk(16'h0008, 32'h0, 4'd14, 1, 0, 1, 0), 64'h0);
        expect_fault("R4 segment flag", 8'd13, 16'd58);
    endtask

    task automatic t_priv;
        issue(8'd9, 1'b1, 2'd3, 16'h0FFF, 1'b0, mk(16'h0008, 32'h40, 4'd14, 0, 2'd0, 1, 0), 64'h0);
        expect_fault("R5 sw dpl<cpl", 8'd13, 16'd74);
        issue(8'd9, 1'b0, 2'd3, 16'h0FFF, 1'b0, mk(16'h0008, 32'h40, 4'd14, 0, 2'd0, 1, 0), 64'h0);
        expect_pass("R5 hw ignores dpl", 16'h0008, 64'h40, 3'd0, 1'b1, 1'b0);
        issue(8'd9, 1'b1, 2'd3, 16'h0FFF, 1'b0, mk(16'h0008, 32'h40, 4'd14, 0, 2'd3, 1, 0), 64'h0);
        expect_pass("R5 sw dpl==cpl", 16'h0008, 64'h40, 3'd0, 1'b1, 1'b0);
    endtask

    task automatic t_present_sel;
        issue(8'd10, 1'b0, 2'd0, 16'h0FFF, 1'b0, mk(16'h0008, 32'h0, 4'd14, 0, 0, 0, 0), 64'h0);
        expect_fault("R6 not present", 8'd11, 16'd82);
        issue(8'd10, 1'b0, 2'd0, 16'h0FFF, 1'b0, mk(16'h0003, 32'h0, 4'd15, 0, 0, 1, 0), 64'h0);
        expect_fault("R7 null selector", 8'd13, 16'd0);
    endtask

    task automatic t_priority;
        issue(8'd12, 1'b1, 2'd3, 16'h0FFF, 1'b0, mk(16'h0008, 32'h0, 4'd14, 0, 2'd0, 0, 0), 64'h0);
        expect_fault("R8 priv before present", 8'd13, 16'd98);
        issue(8'd12, 1'b0, 2'd0, 16'h0FFF, 1'b0, mk(16'h0000, 32'h0, 4'd14, 0, 0, 0, 0), 64'h0);
        expect_fault("R8 present before selector", 8'd11, 16'd98);
        issue(8'd12, 1'b0, 2'd0, 16'h0FFF, 1'b0, mk(16'h0008, 32'h0, 4'd3, 0, 0, 0, 0), 64'h0);
        expect_fault("R8 type before present", 8'd13, 16'd98);
    endtask

    task automatic t_idle;
        @(negedge clk);
        chk("R1 idle rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R1 idle pass", 64'(pass), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_pass_prot();
        t_pass_long();
        t_limit();
        t_rsvd();
        t_type();
        t_priv();
        t_present_sel();
        t_priority();
        t_idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule